// File: doc/BRIEF.md
# Two-Source Byte Permute Unit with Per-Byte Operations

This block builds a 128-bit result one byte at a time from two 128-bit data words and a 128-bit control word. Each of the sixteen output bytes has its own control byte. The low five bits of that byte pick one byte out of the 32 bytes held by the two data words. The top three bits choose what happens to the picked byte before it is written. The byte can pass unchanged, have its bit order mirrored, be replaced by zero, or be filled with copies of its top bit. Each of these results can also be complemented.

Because every lane picks freely from both words, one operation covers several jobs. It can splice two words at any byte offset, shuffle bytes within a single word, broadcast one byte to many lanes, and mask or sign-extend lanes. All sixteen lanes work in parallel from the same sample of the inputs. The result is held in one output register.

A two-state controller tracks that register. It sits in `ST_EMPTY` until a transfer is offered. The transition `GO_FILL` (input valid while empty) moves it to `ST_FULL`. `GO_REFILL` (input valid while full) keeps it in `ST_FULL`. `GO_DRAIN` (no input while full) returns it to `ST_EMPTY`. `GO_IDLE` (no input while empty) keeps it in `ST_EMPTY`. The output valid flag is high exactly in `ST_FULL`.

Top module: `byte_perm_unit`

## Requirements
- R1: While reset is low, and on the first clock after it, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` in a cycle equals `in_valid` sampled at the previous rising clock edge.
- R3: For output lane i (bits 8i+7:8i), control byte bits 4:0 give an index k. For k from 0 to 15 the picked byte is `src_a` byte k, and for k from 16 to 31 it is `src_b` byte k-16. With bits 7:5 = 000 the picked byte is written unchanged.
- R4: Operation code 001 writes the bitwise complement of the picked byte.
- R5: Code 010 writes the picked byte with bit j moved to bit 7-j. Code 011 writes the complement of that mirrored byte.
- R6: Code 100 writes 8'h00 and code 101 writes 8'hFF, whatever the source data.
- R7: Code 110 writes eight copies of bit 7 of the picked byte (8'h00 or 8'hFF). Code 111 writes the complement of that.
- R8: Each lane uses only its own control byte. Any number of lanes may pick the same source byte, and a mix of codes across lanes is applied lane by lane.
- R9: In a cycle where `in_valid` is low, `out_data` keeps its previous value, and the sources and control on that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sources and control are presented this cycle |
| src_a | input | 128 | First data word, bytes 0..15 of the pool |
| src_b | input | 128 | Second data word, bytes 16..31 of the pool |
| sel | input | 128 | Sixteen control bytes, one per output lane |
| out_valid | output | 1 | Registered result is fresh |
| out_data | output | 128 | Registered permuted result |

## Verification
The byte pick and the byte operation happen in the same lane in the same cycle. They can also happen in different lanes that pick the same source byte. The bench provokes this in two ways. It broadcasts one source byte to every lane while varying the operation code per lane. It also runs random control words that mix indices from both words with all eight codes. A second overlap is between a refill and a hold. Random valid patterns make `GO_REFILL` and `GO_DRAIN` alternate. A behavioural model predicts both the valid flag and the held or reloaded data after every edge.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 3;

    // Operation field of a control byte (bits 7:5); bit 0 of the code complements
    typedef enum logic [OP_W-1:0] {
        OP_COPY    = 3'b000,
        OP_NCOPY   = 3'b001,
        OP_MIRROR  = 3'b010,
        OP_NMIRROR = 3'b011,
        OP_ZERO    = 3'b100,
        OP_ONES    = 3'b101,
        OP_SIGN    = 3'b110,
        OP_NSIGN   = 3'b111
    } byte_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_e;

endpackage

// File: rtl/bperm_pick.sv
module bperm_pick #(
    parameter int LANES = 16
) (
    input  logic [2*LANES*bperm_pkg::BYTE_W-1:0]  pool,
    input  logic [$clog2(2*LANES)-1:0]            idx,
    output logic [bperm_pkg::BYTE_W-1:0]          picked
);
    import bperm_pkg::*;

    localparam int POOL_N = 2 * LANES;

    always_comb begin
        picked = '0;
        for (int k = 0; k < POOL_N; k++) begin
            if (int'(idx) == k) begin
                picked = pool[k*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/bperm_xform.sv
module bperm_xform (
    input  logic [bperm_pkg::BYTE_W-1:0] din,
    input  bperm_pkg::byte_op_e          op,
    output logic [bperm_pkg::BYTE_W-1:0] dout
);
    import bperm_pkg::*;

    logic [BYTE_W-1:0] mirrored;
    logic [BYTE_W-1:0] base;
    logic              flip;

    always_comb begin
        for (int j = 0; j < BYTE_W; j++) begin
            mirrored[j] = din[BYTE_W-1-j];
        end
    end

    always_comb begin
        flip = 1'b0;
        base = din;
        unique case (op)
            OP_COPY:    begin base = din;                     flip = 1'b0; end
            OP_NCOPY:   begin base = din;                     flip = 1'b1; end
            OP_MIRROR:  begin base = mirrored;                flip = 1'b0; end
            OP_NMIRROR: begin base = mirrored;                flip = 1'b1; end
            OP_ZERO:    begin base = '0;                      flip = 1'b0; end
            OP_ONES:    begin base = '0;                      flip = 1'b1; end
            OP_SIGN:    begin base = {BYTE_W{din[BYTE_W-1]}}; flip = 1'b0; end
            OP_NSIGN:   begin base = {BYTE_W{din[BYTE_W-1]}}; flip = 1'b1; end
            default:    begin base = din;                     flip = 1'b0; end
        endcase
        dout = flip ? ~base : base;
    end

endmodule

// File: rtl/bperm_ctrl.sv
module bperm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic load_en,
    output logic full
);
    import bperm_pkg::*;

    hold_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: GO_FILL, GO_REFILL, GO_DRAIN, GO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        load_en = in_valid;
        full    = (state_q == ST_FULL);
    end

endmodule

// File: rtl/byte_perm_unit.sv
module byte_perm_unit #(
    parameter int LANES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [LANES*bperm_pkg::BYTE_W-1:0] src_a,
    input  logic [LANES*bperm_pkg::BYTE_W-1:0] src_b,
    input  logic [LANES*bperm_pkg::BYTE_W-1:0] sel,
    output logic                          out_valid,
    output logic [LANES*bperm_pkg::BYTE_W-1:0] out_data
);
    import bperm_pkg::*;

    localparam int WORD_W = LANES * BYTE_W;
    localparam int IDX_W  = $clog2(2 * LANES);
    localparam int OP_LSB = BYTE_W - OP_W;

    logic [2*WORD_W-1:0] pool;
    logic [WORD_W-1:0]   lane_res;
    logic                load_en;
    logic                full;

    assign pool = {src_b, src_a};

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [BYTE_W-1:0] ctl;
            logic [BYTE_W-1:0] picked;
            byte_op_e          op;

            assign ctl = sel[g*BYTE_W +: BYTE_W];
            assign op  = byte_op_e'(ctl[BYTE_W-1:OP_LSB]);

            if (IDX_W < OP_LSB) begin : g_spare
                logic unused_bits;
                assign unused_bits = ^ctl[OP_LSB-1:IDX_W];
            end

            bperm_pick #(.LANES(LANES)) u_pick (
                .pool   (pool),
                .idx    (ctl[IDX_W-1:0]),
                .picked (picked)
            );

            bperm_xform u_xform (
                .din  (picked),
                .op   (op),
                .dout (lane_res[g*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    bperm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .load_en  (load_en),
        .full     (full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (load_en) begin
            out_data <= lane_res;
        end
    end

    assign out_valid = full;

endmodule

// File: rtl/bperm_chk.sv
module bperm_chk #(
    parameter int LANES = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [LANES*8-1:0]    src_a,
    input logic [LANES*8-1:0]    sel,
    input logic                  out_valid,
    input logic [LANES*8-1:0]    out_data
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R9
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
            // R3
            identity_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && sel[g*8 +: 8] == 8'(g))
                |=> out_data[g*8 +: 8] == $past(src_a[g*8 +: 8]));

            // R6
            zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && sel[g*8+5 +: 3] == 3'b100) |=> out_data[g*8 +: 8] == 8'h00);

            // R7
            sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && sel[g*8+6 +: 2] == 2'b11)
                |=> (out_data[g*8 +: 8] == 8'h00 || out_data[g*8 +: 8] == 8'hFF));
        end
    endgenerate

endmodule

bind byte_perm_unit bperm_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .sel       (sel),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_byte_perm_unit.sv
`timescale 1ns/1ps
module sim_byte_perm_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] sel = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic         exp_valid = 1'b0;
    logic [127:0] exp_data  = '0;

    always #2 clk = ~clk;

    byte_perm_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .sel(sel),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [7:0] ref_byte(logic [127:0] a, logic [127:0] b, logic [7:0] c);
        int k;
        logic [7:0] v, r;
        k = int'(c[4:0]);
        v = (k < 16) ? a[k*8 +: 8] : b[(k-16)*8 +: 8];
        case (c[7:5])
            3'd0: r = v;
            3'd1: r = ~v;
            3'd2: r = {v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]};
            3'd3: r = ~{v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]};
            3'd4: r = 8'h00;
            3'd5: r = 8'hFF;
            3'd6: r = v[7] ? 8'hFF : 8'h00;
            default: r = v[7] ? 8'h00 : 8'hFF;
        endcase
        return r;
    endfunction

    function automatic logic [127:0] ref_word(logic [127:0] a, logic [127:0] b, logic [127:0] c);
        logic [127:0] w;
        for (int i = 0; i < 16; i++) w[i*8 +: 8] = ref_byte(a, b, c[i*8 +: 8]);
        return w;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic compare(string tag);
        n_checks++;
        if (out_valid !== exp_valid || out_data !== exp_data) begin
            n_fails++;
            $display("FAIL %s: got valid=%b data=%h, expected valid=%b data=%h",
                     tag, out_valid, out_data, exp_valid, exp_data);
        end
    endtask

    // Drive at falling edge, update model at rising edge, sample 1 ns later
    task automatic step(logic v, logic [127:0] a, logic [127:0] b, logic [127:0] c, string tag);
        @(negedge clk);
        in_valid = v; src_a = a; src_b = b; sel = c;
        @(posedge clk);
        exp_valid = v;
        if (v) exp_data = ref_word(a, b, c);
        #1;
        compare(tag);
    endtask

    function automatic logic [127:0] fill_sel(logic [2:0] op, int base);
        logic [127:0] c;
        for (int i = 0; i < 16; i++) c[i*8 +: 8] = {op, 5'((base + i) % 32)};
        return c;
    endfunction

    initial begin
        logic [127:0] a, b, c;
        a = 128'h8F7E6D5C4B3A29180716253443526170;
        b = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;

        repeat (3) @(posedge clk);
        #1;
        exp_valid = 1'b0; exp_data = '0;
        compare("R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        step(1, a, b, fill_sel(3'd0, 0),  "R3 copy from src_a");
        step(1, a, b, fill_sel(3'd0, 16), "R3 copy from src_b");
        step(1, a, b, fill_sel(3'd1, 3),  "R4 complement");
        step(1, a, b, fill_sel(3'd2, 7),  "R5 mirror");
        step(1, a, b, fill_sel(3'd3, 20), "R5 complemented mirror");
        step(1, a, b, fill_sel(3'd4, 9),  "R6 zero");
        step(1, a, b, fill_sel(3'd5, 30), "R6 all ones");
        step(1, a, b, fill_sel(3'd6, 0),  "R7 sign fill");
        step(1, a, b, fill_sel(3'd7, 16), "R7 complemented sign fill");
        step(1, a, b, fill_sel(3'd0, 5),  "R8 splice at offset 5");

        // Broadcast one byte with per-lane codes
        for (int i = 0; i < 16; i++) c[i*8 +: 8] = {3'(i % 8), 5'd18};
        step(1, a, b, c, "R8 broadcast mixed codes");

        // Inputs ignored while not valid
        step(0, rnd128(), rnd128(), rnd128(), "R9 hold after drop");
        step(0, rnd128(), rnd128(), rnd128(), "R9 hold second idle");

        for (int n = 0; n < 400; n++) begin
            step(($urandom % 3) != 0, rnd128(), rnd128(), rnd128(), "R2 R8 R9 random");
        end

        // Reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        exp_valid = 1'b0; exp_data = '0;
        compare("R1 reset mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        step(1, a, b, fill_sel(3'd2, 31), "R5 after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule